// File: doc/BRIEF.md
# Translation Map Replay Scanner

This block replays the contents of a page translation table to a downstream consumer. A start pulse makes it step through an I/O virtual address window. The window begins at address zero and ends at the entry count multiplied by the page size. The scanner moves one page at a time. For each page it sends a lookup to an external table and waits for the raw entry to come back. An entry whose permission field is not zero becomes one notification on a valid/ready stream. The notification carries the page-aligned IOVA, the page-aligned translated address, the in-page offset mask and the permission. Entries with no permission are dropped without any output.

A skip flag sampled with the start pulse makes the run finish at once, with no lookups. If adding one page to the current address would carry out of the address width, the walk ends after that page, even when the window is larger. This stops an endless loop near the top of the address space. The page shift and the entry count are captured when start is accepted. Start has no effect while a run is in progress.

Control is one state machine:
- IDLE goes to ISSUE on start without skip, and to FINISH on start with skip.
- ISSUE places a lookup and goes to WAIT when the address is inside the window. Otherwise it goes to FINISH.
- WAIT goes to EMIT on a response with non-zero permission, and to STEP on a response with zero permission.
- EMIT goes to STEP once the notification is accepted.
- STEP goes to ISSUE with the advanced address. When the increment would wrap, it goes to FINISH instead.
- FINISH raises done and returns to IDLE.

Top module: `replay_scanner`

## Requirements
- R1: After an accepted start, lookup addresses are 0, G, 2G, … with G = 2^page_shift. A lookup is issued exactly for each such address below entry_count << page_shift. An entry count of zero gives no lookup.
- R2: At most one lookup is outstanding. No request is issued between a request and its response.
- R3: Bits [1:0] of a returned entry are its permission: 0 none, 1 read, 2 write, 3 read/write. Exactly the lookups with non-zero permission produce a notification, in address order, and note_perm never shows 0.
- R4: A notification reports note_iova = lookup address & M, note_xlat = entry & M, note_mask = ~M and note_perm = entry[1:0], where M = ~(G-1).
- R5: When address + G overflows the ADDR_W-bit address, the walk ends after the lookup for that address, whatever the window size.
- R6: A start with skip high produces no lookup and no notification, and done still pulses once.
- R7: While note_valid is high and note_ready is low, note_valid stays high and the notification fields hold their values.
- R8: Each accepted start produces exactly one done pulse, one cycle wide, after the last lookup response and the last notification handshake.
- R9: After reset, lk_req_valid, note_valid and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run (accepted only in IDLE) |
| skip | input | 1 | Sampled with start; finish with no lookups |
| page_shift | input | SHIFT_W | Log2 of page size and scan step |
| entry_count | input | CNT_W | Number of table entries in the window |
| lk_req_valid | output | 1 | One-cycle lookup request |
| lk_req_addr | output | ADDR_W | Address being looked up |
| lk_rsp_valid | input | 1 | Lookup response strobe |
| lk_rsp_entry | input | ADDR_W | Raw table entry, permission in bits [1:0] |
| note_valid | output | 1 | Notification available |
| note_ready | input | 1 | Consumer accepts notification |
| note_iova | output | ADDR_W | Page-aligned IOVA |
| note_xlat | output | ADDR_W | Page-aligned translated address |
| note_mask | output | ADDR_W | In-page offset mask |
| note_perm | output | 2 | Permission of the mapping |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
The walk runs with several patterns of page shift and entry count. A small window with an always-ready consumer checks the step size and the permission filter. A 16-byte page with a longer window, slow responses and a consumer that stalls two cycles in three checks that nothing moves during backpressure and that lookups never overlap. A zero-entry window and a skipped start show that no lookup is made. A window larger than the address space shows the wrap stop: an implementation without it would keep lookups going past sixteen and would never raise done.

// File: rtl/replay_scan_pkg.sv
package replay_scan_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_EMIT,
        S_STEP,
        S_FINISH
    } scan_state_t;

    localparam logic [1:0] PERM_NONE = 2'd0;

endpackage

// File: rtl/replay_window.sv
module replay_window #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic [SHIFT_W-1:0] shift,
    input  logic [CNT_W-1:0]   count,
    input  logic [ADDR_W-1:0]  addr,
    output logic [ADDR_W-1:0]  gran,
    output logic [ADDR_W-1:0]  page_mask,
    output logic               in_window
);
    // Window size may exceed the address space; keep it wide enough to hold
    // any count shifted by any legal shift without loss.
    localparam int WIN_W = CNT_W + (1 << SHIFT_W);

    logic [WIN_W-1:0] win_size;

    always_comb begin
        gran      = ADDR_W'(1) << shift;
        page_mask = ~(gran - ADDR_W'(1));
        win_size  = WIN_W'(count) << shift;
        in_window = WIN_W'(addr) < win_size;
    end

endmodule

// File: rtl/replay_addr_gen.sv
module replay_addr_gen #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [ADDR_W-1:0] gran,
    output logic [ADDR_W-1:0] addr,
    output logic              wrap
);
    logic [ADDR_W:0] sum;

    always_comb begin
        sum  = {1'b0, addr} + {1'b0, gran};
        wrap = sum[ADDR_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (clear) begin
            addr <= '0;
        end else if (advance) begin
            addr <= sum[ADDR_W-1:0];
        end
    end

endmodule

// File: rtl/replay_scanner.sv
module replay_scanner
    import replay_scan_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int SHIFT_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               skip,
    input  logic [SHIFT_W-1:0] page_shift,
    input  logic [CNT_W-1:0]   entry_count,
    output logic               lk_req_valid,
    output logic [ADDR_W-1:0]  lk_req_addr,
    input  logic               lk_rsp_valid,
    input  logic [ADDR_W-1:0]  lk_rsp_entry,
    output logic               note_valid,
    input  logic               note_ready,
    output logic [ADDR_W-1:0]  note_iova,
    output logic [ADDR_W-1:0]  note_xlat,
    output logic [ADDR_W-1:0]  note_mask,
    output logic [1:0]         note_perm,
    output logic               done
);
    scan_state_t state, state_nx;

    logic [SHIFT_W-1:0] shift_q;
    logic [CNT_W-1:0]   count_q;
    logic [ADDR_W-1:0]  entry_q;
    logic [ADDR_W-1:0]  addr;
    logic [ADDR_W-1:0]  gran;
    logic [ADDR_W-1:0]  page_mask;
    logic               in_window;
    logic               wrap;
    logic               accept;
    logic               step_go;

    replay_window #(
        .ADDR_W (ADDR_W),
        .CNT_W  (CNT_W),
        .SHIFT_W(SHIFT_W)
    ) u_window (
        .shift    (shift_q),
        .count    (count_q),
        .addr     (addr),
        .gran     (gran),
        .page_mask(page_mask),
        .in_window(in_window)
    );

    replay_addr_gen #(
        .ADDR_W(ADDR_W)
    ) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (accept),
        .advance(step_go),
        .gran   (gran),
        .addr   (addr),
        .wrap   (wrap)
    );

    assign accept  = (state == S_IDLE) && start;
    assign step_go = (state == S_STEP) && !wrap;

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (start) state_nx = skip ? S_FINISH : S_ISSUE;
            S_ISSUE:  state_nx = in_window ? S_WAIT : S_FINISH;
            S_WAIT: begin
                if (lk_rsp_valid) begin
                    state_nx = (lk_rsp_entry[1:0] != PERM_NONE) ? S_EMIT : S_STEP;
                end
            end
            S_EMIT:   if (note_ready) state_nx = S_STEP;
            S_STEP:   state_nx = wrap ? S_FINISH : S_ISSUE;
            S_FINISH: state_nx = S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    // State register and captured run data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= S_IDLE;
            shift_q <= '0;
            count_q <= '0;
            entry_q <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                shift_q <= page_shift;
                count_q <= entry_count;
            end
            if ((state == S_WAIT) && lk_rsp_valid) begin
                entry_q <= lk_rsp_entry;
            end
        end
    end

    // Outputs decoded from state
    always_comb begin
        lk_req_valid = (state == S_ISSUE) && in_window;
        lk_req_addr  = addr;
        note_valid   = (state == S_EMIT);
        note_iova    = addr & page_mask;
        note_xlat    = entry_q & page_mask;
        note_mask    = ~page_mask;
        note_perm    = entry_q[1:0];
        done         = (state == S_FINISH);
    end

endmodule

// File: rtl/replay_scanner_chk.sv
module replay_scanner_chk #(
    parameter int ADDR_W  = 16,
    parameter int CNT_W   = 16,
    parameter int SHIFT_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start,
    input logic               skip,
    input logic [SHIFT_W-1:0] page_shift,
    input logic [CNT_W-1:0]   entry_count,
    input logic               lk_req_valid,
    input logic [ADDR_W-1:0]  lk_req_addr,
    input logic               lk_rsp_valid,
    input logic [ADDR_W-1:0]  lk_rsp_entry,
    input logic               note_valid,
    input logic               note_ready,
    input logic [ADDR_W-1:0]  note_iova,
    input logic [ADDR_W-1:0]  note_xlat,
    input logic [ADDR_W-1:0]  note_mask,
    input logic [1:0]         note_perm,
    input logic               done
);
    logic outst;
    logic busy;
    logic skip_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            outst    <= 1'b0;
            busy     <= 1'b0;
            skip_run <= 1'b0;
        end else begin
            if (lk_req_valid) outst <= 1'b1;
            else if (lk_rsp_valid) outst <= 1'b0;
            if (done) begin
                busy     <= 1'b0;
                skip_run <= 1'b0;
            end else if (start && !busy) begin
                busy     <= 1'b1;
                skip_run <= skip;
            end
        end
    end

    assert_one_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req_valid |-> !outst);

    assert_perm_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> (note_perm != 2'd0));

    assert_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        note_valid |-> (((note_iova & note_mask) == '0) && ((note_xlat & note_mask) == '0)));

    assert_skip_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        skip_run |-> (!lk_req_valid && !note_valid));

    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid && !note_ready) |=> (note_valid && $stable(note_iova)
                                          && $stable(note_xlat) && $stable(note_perm)));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

bind replay_scanner replay_scanner_chk #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .SHIFT_W(SHIFT_W)
) u_chk (.*);

// File: tb/replay_scanner_test.sv
module replay_scanner_test;
    localparam int AW = 16;
    localparam int CW = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          skip = 1'b0;
    logic [SW-1:0] page_shift = '0;
    logic [CW-1:0] entry_count = '0;
    logic          lk_req_valid;
    logic [AW-1:0] lk_req_addr;
    logic          lk_rsp_valid = 1'b0;
    logic [AW-1:0] lk_rsp_entry = '0;
    logic          note_valid;
    logic          note_ready = 1'b1;
    logic [AW-1:0] note_iova, note_xlat, note_mask;
    logic [1:0]    note_perm;
    logic          done;

    replay_scanner #(.ADDR_W(AW), .CNT_W(CW), .SHIFT_W(SW)) uut (.*);

    always #2 clk = ~clk;

    int total = 0;
    int bad = 0;
    int cyc = 0;

    // environment state
    int            lat = 1;
    int            rmode = 0;
    logic [AW-1:0] seed = '0;
    int            pend = 0;
    logic [AW-1:0] pend_addr = '0;
    int            n_req = 0;
    int            n_note = 0;
    int            n_done = 0;
    int            viol = 0;
    logic          stalled = 1'b0;
    logic [AW-1:0] prev_iova = '0, prev_xlat = '0;
    logic [1:0]    prev_perm = '0;
    logic [AW-1:0] req_log [0:127];
    logic [AW-1:0] g_iova [0:127];
    logic [AW-1:0] g_xlat [0:127];
    logic [AW-1:0] g_mask [0:127];
    logic [1:0]    g_perm [0:127];

    function automatic logic [AW-1:0] entry_of(input logic [AW-1:0] a, input logic [SW-1:0] sh,
                                               input logic [AW-1:0] sd);
        logic [AW-1:0] idx;
        idx = a >> sh;
        return (idx * 16'h0135) ^ sd;
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // lookup responder
    always @(negedge clk) begin
        lk_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                lk_rsp_valid = 1'b1;
                lk_rsp_entry = entry_of(pend_addr, page_shift, seed);
            end
        end
        if (lk_req_valid) begin
            if (n_req < 128) req_log[n_req] = lk_req_addr;
            n_req++;
            pend_addr = lk_req_addr;
            pend = lat;
        end
    end

    // notification consumer and done monitor
    always @(negedge clk) begin
        logic r;
        r = (rmode == 0) ? 1'b1 : ((cyc % 3) == 0);
        note_ready = r;
        if (note_valid && stalled &&
            (note_iova != prev_iova || note_xlat != prev_xlat || note_perm != prev_perm)) viol++;
        if (stalled && !note_valid) viol++;
        if (note_valid && r) begin
            if (n_note < 128) begin
                g_iova[n_note] = note_iova;
                g_xlat[n_note] = note_xlat;
                g_mask[n_note] = note_mask;
                g_perm[n_note] = note_perm;
            end
            n_note++;
        end
        stalled   = note_valid && !r;
        prev_iova = note_iova;
        prev_xlat = note_xlat;
        prev_perm = note_perm;
        if (done) n_done++;
    end

    task automatic run_and_check(input string tag, input int sh, input int cnt, input bit sk,
                                 input logic [AW-1:0] sd, input int latency, input int rm);
        longint unsigned size, a, g;
        int exp_req, exp_note, k;
        logic [AW-1:0] e, pm;
        @(negedge clk);
        n_req = 0; n_note = 0; n_done = 0; viol = 0;
        seed = sd; lat = latency; rmode = rm;
        page_shift = SW'(sh); entry_count = CW'(cnt); skip = sk; start = 1'b1;
        @(negedge clk);
        start = 1'b0; skip = 1'b0;
        for (int i = 0; i < 5000 && n_done == 0; i++) @(negedge clk);
        repeat (6) @(negedge clk);

        g = 64'd1 << sh;
        pm = ~(AW'(g) - AW'(1));
        size = 64'(cnt) << sh;
        exp_req = 0; exp_note = 0; a = 0;
        if (!sk) begin
            while (a < size) begin
                e = entry_of(AW'(a), SW'(sh), sd);
                if (exp_req < 128 && exp_req < n_req)
                    chk(req_log[exp_req] == AW'(a), {tag, " R1 addr"}, req_log[exp_req], a);
                if (e[1:0] != 2'd0) begin
                    k = exp_note;
                    if (k < n_note && k < 128) begin
                        chk(g_iova[k] == (AW'(a) & pm), {tag, " R4 iova"}, g_iova[k], AW'(a) & pm);
                        chk(g_xlat[k] == (e & pm), {tag, " R4 xlat"}, g_xlat[k], e & pm);
                        chk(g_mask[k] == ~pm, {tag, " R4 mask"}, g_mask[k], ~pm);
                        chk(g_perm[k] == e[1:0], {tag, " R3 perm"}, g_perm[k], e[1:0]);
                    end
                    exp_note++;
                end
                exp_req++;
                if (a + g > 64'hFFFF) break;   // R5 wrap stop
                a = a + g;
            end
        end
        chk(n_req == exp_req, {tag, " R1 lookup count"}, n_req, exp_req);
        chk(n_note == exp_note, {tag, " R3 notification count"}, n_note, exp_note);
        chk(n_done == 1, {tag, " R8 done pulses"}, n_done, 1);
        chk(viol == 0, {tag, " R7 stall hold"}, viol, 0);
    endtask

    task automatic test_reset;
        @(negedge clk);
        chk(lk_req_valid == 1'b0, "R9 req after reset", lk_req_valid, 0);
        chk(note_valid == 1'b0, "R9 note after reset", note_valid, 0);
        chk(done == 1'b0, "R9 done after reset", done, 0);
    endtask

    task automatic test_plain;      // R1 R3 R4 R8
        run_and_check("plain", 8, 10, 1'b0, 16'h5a3c, 1, 0);
    endtask

    task automatic test_stall;      // R2 R7 with slow table and backpressure
        run_and_check("stall", 4, 37, 1'b0, 16'h1e07, 3, 1);
    endtask

    task automatic test_empty;      // R1 zero-entry window
        run_and_check("empty", 6, 0, 1'b0, 16'h0000, 1, 0);
    endtask

    task automatic test_skip;       // R6
        run_and_check("skip R6", 8, 10, 1'b1, 16'h5a3c, 1, 0);
        chk(n_req == 0, "R6 no lookups", n_req, 0);
    endtask

    task automatic test_wrap;       // R5 window beyond address space
        run_and_check("wrap R5", 12, 20, 1'b0, 16'h7777, 2, 0);
        chk(n_req == 16, "R5 walk ends at top", n_req, 16);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        test_reset();
        test_plain();
        test_stall();
        test_empty();
        test_skip();
        test_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule